// File: doc/BRIEF.md
# Retriggerable Interval Timer

This block is a one-shot interval timer made of a small control state machine and a tick counter. A falling edge on the active-low trigger input starts a timing period of fixed length. The output stays high until a set number of time-base ticks has been counted, then drops. The time base is a slow clock, 50 Hz by default, so each tick stands for 20 ms. The default period of 925 ticks gives 18.5 s, and a 16-bit counter allows periods of up to about 21 min 50 s.

A mode input chooses what a trigger edge does while a period is running. In retriggerable mode it clears the count and starts the period again, so triggers that keep arriving in time hold the output high indefinitely. In the other mode the edge is ignored. The trigger and the time-base clock are asynchronous to the system clock. Each one goes through a synchroniser and an edge detector inside the block. The mode is sampled every clock cycle, and the state machine stores the sampled value when it accepts a trigger. All pins are plain control levels with no handshake and no back-pressure. A one-cycle done pulse marks the end of each period.

Top module: `retrig_oneshot`

## Requirements
- R1: Reset (rst_n low) puts the block in idle with a cleared count. pulse_out and period_done are 0 while reset is held and after it is released, until a trigger arrives.
- R2: A 1-to-0 transition of trig_n while idle sets pulse_out to 1 within 5 clock cycles. Holding trig_n low after that edge starts no further period.
- R3: pulse_out stays 1 through PERIOD_TICKS - 1 rising edges of tb_clk counted from the start of the period, and returns to 0 within 5 clock cycles of the PERIOD_TICKS-th rising edge.
- R4: Each completed period gives exactly one period_done pulse, one clock cycle long, in the cycle after pulse_out falls.
- R5: In retriggerable mode (retrig_mode = 1 at the accepted trigger), a trigger edge during timing clears the count. pulse_out then stays 1 for PERIOD_TICKS further rising edges of tb_clk. This also holds when the edge arrives right after the last tick but one.
- R6: In non-retriggerable mode (retrig_mode = 0 at the accepted trigger), trigger edges during timing are ignored, and the period ends after PERIOD_TICKS ticks from its start.
- R7: The mode stored at the accepted trigger governs the whole period. A change on retrig_mode during the period only takes effect at the next accepted trigger.
- R8: Rising edges of tb_clk while idle are not counted. The next period after them still lasts the full PERIOD_TICKS ticks.
- R9: The tick count stays below PERIOD_TICKS, which must be less than 2^CNT_W. The counter only advances while timing.
- R10: After a period ends, pulse_out stays 0 until the next trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| trig_n | input | 1 | Active-low trigger, asynchronous; its falling edge starts a period |
| tb_clk | input | 1 | Time-base clock, asynchronous; each rising edge is one tick |
| retrig_mode | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| pulse_out | output | 1 | High for the duration of the timing period |
| period_done | output | 1 | One-cycle pulse when a period completes |

## Verification
A single trigger in each mode shows the basic period length and that the two modes agree when no second trigger arrives. A second trigger at mid-period, and another right after the last tick but one, separate a restart from an ignored edge. The late trigger also exposes an off-by-one at the terminal count. Extra ticks after the period, a trigger held low, a mode flip mid-period and a reset mid-period cover the idle, single-edge, mode-capture and reset behaviour.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_TIMING = 2'd2,
    ST_STOP   = 2'd3
  } os_state_t;
endpackage

// File: rtl/oneshot_edge_sync.sv
// Multi-stage synchroniser followed by a single-cycle edge detector.
module oneshot_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              held;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      held  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      held  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~held;
  assign fall  = ~level & held;
endmodule

// File: rtl/oneshot_tick_counter.sv
// Datapath: binary up counter that wraps modulo 2^CNT_W, with terminal-count flag.
module oneshot_tick_counter #(
  parameter int CNT_W        = 16,
  parameter int PERIOD_TICKS = 925
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(PERIOD_TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign last = (count == TERM);
endmodule

// File: rtl/oneshot_ctrl.sv
// Control unit: idle / setup / timing / stop sequencer.
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig_fall,
  input  logic      tick_rise,
  input  logic      mode_sample,
  input  logic      cnt_last,
  output os_state_t state,
  output logic      run_mode,
  output logic      cnt_clr,
  output logic      cnt_inc,
  output logic      pulse,
  output logic      done
);
  os_state_t nxt;
  logic      restart;
  logic      accept;

  assign restart = (state == ST_TIMING) && trig_fall && run_mode;
  assign accept  = ((state == ST_IDLE) && trig_fall) || restart;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (trig_fall) nxt = ST_SETUP;
      ST_SETUP:  nxt = ST_TIMING;
      ST_TIMING: begin
        if (restart)                    nxt = ST_SETUP;
        else if (tick_rise && cnt_last) nxt = ST_STOP;
      end
      ST_STOP:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      run_mode <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) run_mode <= mode_sample;
    end
  end

  assign cnt_clr = (state != ST_TIMING) || (tick_rise && cnt_last && !restart);
  assign cnt_inc = (state == ST_TIMING) && tick_rise && !restart;
  assign pulse   = (state == ST_SETUP) || (state == ST_TIMING);
  assign done    = (state == ST_STOP);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int PERIOD_TICKS = 925,
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_n,
  input  logic tb_clk,
  input  logic retrig_mode,
  output logic pulse_out,
  output logic period_done
);
  logic             trig_fall, trig_rise_unused;
  logic             tick_rise, tick_fall_unused;
  logic             mode_q;
  logic             cnt_clr, cnt_inc, cnt_last, run_mode;
  logic [CNT_W-1:0] count;
  os_state_t        state_q;

  oneshot_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_n),
    .rise(trig_rise_unused), .fall(trig_fall)
  );

  oneshot_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tick_sync (
    .clk(clk), .rst_n(rst_n), .din(tb_clk),
    .rise(tick_rise), .fall(tick_fall_unused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= retrig_mode;
  end

  oneshot_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trig_fall(trig_fall), .tick_rise(tick_rise),
    .mode_sample(mode_q), .cnt_last(cnt_last),
    .state(state_q), .run_mode(run_mode),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .pulse(pulse_out), .done(period_done)
  );

  oneshot_tick_counter #(.CNT_W(CNT_W), .PERIOD_TICKS(PERIOD_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .count(count), .last(cnt_last)
  );
endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker
  import oneshot_pkg::*;
#(
  parameter int PERIOD_TICKS = 925,
  parameter int CNT_W        = 16
) (
  input logic             clk,
  input logic             rst_n,
  input os_state_t        state,
  input logic [CNT_W-1:0] count,
  input logic             pulse,
  input logic             done,
  input logic             trig_fall,
  input logic             tick_rise,
  input logic             run_mode
);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count < CNT_W'(PERIOD_TICKS));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fall_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> done);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && trig_fall |=> pulse);

  assert_idle_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && tick_rise |=> count == '0);

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TIMING) && trig_fall && !run_mode && !tick_rise |=>
      (count == $past(count)) && pulse);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TIMING) && trig_fall && run_mode |=> (state == ST_SETUP) && pulse);

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TIMING) && !trig_fall |=> $stable(run_mode));
endmodule

bind retrig_oneshot oneshot_checker #(
  .PERIOD_TICKS(PERIOD_TICKS), .CNT_W(CNT_W)
) u_oneshot_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .count(count),
  .pulse(pulse_out), .done(period_done), .trig_fall(trig_fall),
  .tick_rise(tick_rise), .run_mode(run_mode)
);

// File: tb/retrig_oneshot_test.sv
`timescale 1ns/1ps
module retrig_oneshot_test;
  localparam int P = 6;
  localparam int NV = 6;
  // per vector: mode, tick after which a second trigger is sent (0 = none), ticks until output falls
  localparam int V_MODE [NV] = '{0, 0, 0, 1, 1, 1};
  localparam int V_RTRG [NV] = '{0, 3, 5, 0, 3, 5};
  localparam int V_EXP  [NV] = '{6, 6, 6, 6, 9, 11};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_n = 1'b1;
  logic tb_clk = 1'b0;
  logic retrig_mode = 1'b0;
  logic pulse_out, period_done;
  int checks = 0;
  int fails = 0;
  int done_seen = 0;

  always #2 clk = ~clk;

  retrig_oneshot #(.PERIOD_TICKS(P), .CNT_W(16), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .tb_clk(tb_clk),
    .retrig_mode(retrig_mode), .pulse_out(pulse_out), .period_done(period_done)
  );

  always @(negedge clk) if (rst_n && period_done) done_seen++;

  task automatic check(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig_n = 1'b0;
    repeat (6) @(negedge clk);
    trig_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic one_tick();
    @(negedge clk) tb_clk = 1'b1;
    repeat (4) @(negedge clk);
    tb_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    check(pulse_out, 0, "R1 reset out");
    check(period_done, 0, "R1 reset done");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pulse_out, 0, "R1 after release");

    // table walk: R2 R3 R4 R5 R6 R8 R10
    for (int v = 0; v < NV; v++) begin
      retrig_mode = V_MODE[v][0];
      d0 = done_seen;
      pulse_trig();
      check(pulse_out, 1, "R2 start");
      for (int t = 1; t <= V_EXP[v] + 2; t++) begin
        one_tick();
        check(pulse_out, (t < V_EXP[v]) ? 1 : 0,
              V_MODE[v] != 0 ? "R5 retrig length" : (V_RTRG[v] != 0 ? "R6 ignore" : "R3 period"));
        if (t == V_RTRG[v]) pulse_trig();
      end
      check(pulse_out, 0, "R10 stays low");
      check(done_seen, d0 + 1, "R4 one done pulse");
    end

    // R8: idle ticks then a full period
    one_tick(); one_tick();
    retrig_mode = 1'b0;
    pulse_trig();
    for (int t = 1; t <= P; t++) begin
      one_tick();
      check(pulse_out, (t < P) ? 1 : 0, "R8 full period after idle ticks");
    end

    // R2: trigger held low starts only one period
    @(negedge clk) trig_n = 1'b0;
    repeat (6) @(negedge clk);
    check(pulse_out, 1, "R2 held start");
    for (int t = 1; t <= P + 2; t++) one_tick();
    check(pulse_out, 0, "R2 held no second period");
    trig_n = 1'b1;
    repeat (6) @(negedge clk);
    check(pulse_out, 0, "R10 release no start");

    // R7: mode flipped mid-period does not allow a restart
    retrig_mode = 1'b0;
    pulse_trig();
    retrig_mode = 1'b1;
    one_tick(); one_tick();
    pulse_trig();
    for (int t = 3; t <= P; t++) begin
      one_tick();
      check(pulse_out, (t < P) ? 1 : 0, "R7 captured mode");
    end

    // R1: reset during a period
    pulse_trig();
    one_tick(); one_tick();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(pulse_out, 0, "R1 mid reset out");
    rst_n = 1'b1;
    one_tick();
    check(pulse_out, 0, "R1 idle after reset");
    check(period_done, 0, "R1 no done after reset");

    summary();
  end
endmodule